// File: doc/BRIEF.md
# Legacy Address-Mode Access Checker

This block screens memory access requests for a processor core that can run in a legacy 26-bit address configuration. Two static configuration inputs describe the system: a program-32 enable, which decides whether the core may enter 32-bit modes at all, and a data-32 enable, which decides whether data addresses above 64 MB are allowed while program-32 is off. The block keeps the current 5-bit mode field in a register. It filters writes to that field so that a core configured for 26-bit operation can never reach a 32-bit mode.

For each request the block reports two flags in the same cycle. The address-exception flag fires on an out-of-range data address. The vector-exception flag fires on a data access to the exception vector area that comes from a 26-bit mode while 32-bit operation is enabled; it is reported as a data abort. An option input decides whether data reads of the vector area fault in the same way as data writes. The block also presents a fetch address, which is masked to the 26-bit program space when program-32 is off.

Top module: `legacy_addr_guard`

## Requirements
- R1: While rst_n is low, mode_q loads 5'b00011 (26-bit supervisor) if cfg_prog32 is 0, and 5'b10011 (32-bit supervisor) if cfg_prog32 is 1.
- R2: With cfg_prog32 = 0, a mode write updates only mode_q[1:0]. Bits [4:2] keep their value, so no 32-bit mode can be entered.
- R3: With cfg_prog32 = 1, a mode write (mode_wr_en = 1) loads all five bits of mode_wr_data into mode_q, visible one cycle later.
- R4: With cfg_prog32 = 0 and cfg_data32 = 0, a valid data access (req_fetch = 0) whose address has any bit of [31:26] set raises addr_exc in the same cycle.
- R5: addr_exc stays low whenever cfg_data32 = 1, whenever cfg_prog32 = 1, and for every instruction fetch.
- R6: With cfg_prog32 = 1 and mode_q[4] = 0, a valid data write to addresses 0x00 through 0x1F raises vec_exc in the same cycle. Addresses from 0x20 upward never raise it.
- R7: An instruction fetch (req_fetch = 1) never raises vec_exc.
- R8: A valid data read of 0x00 through 0x1F, under the conditions of R6, raises vec_exc only when cfg_vec_rd_trap = 1.
- R9: vec_exc stays low when mode_q[4] = 1 or when cfg_prog32 = 0.
- R10: Both flags are low while req_valid is low, and the two flags are never high together.
- R11: fetch_pc equals req_addr when cfg_prog32 = 1. When cfg_prog32 = 0 it equals req_addr with bits [31:26] and [1:0] cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_prog32 | input | 1 | Enables 32-bit program configuration |
| cfg_data32 | input | 1 | Enables full 32-bit data addresses while in the 26-bit configuration |
| cfg_vec_rd_trap | input | 1 | Makes data reads of the vector area fault as well |
| mode_wr_en | input | 1 | Mode field write strobe |
| mode_wr_data | input | 5 | Requested mode value |
| req_valid | input | 1 | Access request valid |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| mode_q | output | 5 | Current mode field |
| addr_exc | output | 1 | Address exception flag |
| vec_exc | output | 1 | Vector exception (data abort) flag |
| fetch_pc | output | 32 | Fetch address after the configuration mask |

## Verification
The two flags and fetch_pc are combinational, so each one is due in the cycle its request is presented. The bench drives the request after a falling edge and samples it 1 ns later, with no clock edge in between. A mode write takes effect at the next rising edge, so the bench holds the write for one cycle and reads mode_q after the following falling edge. Reset values are read the same way after reset is released.

// File: rtl/legacy_addr_guard.sv
module legacy_addr_guard #(
  parameter int AW = 32,
  parameter int MW = 5,
  parameter int LEGACY_AW = 26,
  parameter int VEC_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_prog32,
  input  logic          cfg_data32,
  input  logic          cfg_vec_rd_trap,
  input  logic          mode_wr_en,
  input  logic [MW-1:0] mode_wr_data,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_fetch,
  output logic [MW-1:0] mode_q,
  output logic          addr_exc,
  output logic          vec_exc,
  output logic [AW-1:0] fetch_pc
);
  localparam int VEC_AW = $clog2(VEC_BYTES);
  localparam logic [MW-1:0] SVC26 = MW'(5'b00011);
  localparam logic [MW-1:0] SVC32 = MW'(5'b10011);

  logic data_acc, high_bits, in_vec, mode26;
  logic [AW-1:0] legacy_mask;

  always_ff @(posedge clk) begin
    if (!rst_n)
      mode_q <= cfg_prog32 ? SVC32 : SVC26;
    else if (mode_wr_en)
      mode_q <= cfg_prog32 ? mode_wr_data : {mode_q[MW-1:2], mode_wr_data[1:0]};
  end

  assign data_acc  = req_valid && !req_fetch;
  assign high_bits = |req_addr[AW-1:LEGACY_AW];
  assign in_vec    = ~|req_addr[AW-1:VEC_AW];
  assign mode26    = !mode_q[MW-1];

  assign addr_exc = data_acc && !cfg_prog32 && !cfg_data32 && high_bits;
  assign vec_exc  = data_acc && cfg_prog32 && mode26 && in_vec &&
                    (req_write || cfg_vec_rd_trap);

  assign legacy_mask = {{(AW-LEGACY_AW){1'b0}}, {(LEGACY_AW-2){1'b1}}, 2'b00};
  assign fetch_pc    = cfg_prog32 ? req_addr : (req_addr & legacy_mask);
endmodule

module legacy_addr_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_prog32,
  input logic        cfg_data32,
  input logic        req_valid,
  input logic        req_fetch,
  input logic [4:0]  mode_q,
  input logic        addr_exc,
  input logic        vec_exc,
  input logic [31:0] fetch_pc
);
  // R2
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_prog32 |=> $stable(mode_q[4:2]));
  // R5
  data32_no_addr_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_data32 || cfg_prog32 || req_fetch) |-> !addr_exc);
  // R7
  fetch_no_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fetch |-> !vec_exc);
  // R9
  mode32_no_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[4] || !cfg_prog32) |-> !vec_exc);
  // R10
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_exc && vec_exc));
  // R10
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_exc || vec_exc) |-> req_valid);
  // R11
  pc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_prog32 |-> (fetch_pc[31:26] == 6'd0 && fetch_pc[1:0] == 2'd0));
endmodule

bind legacy_addr_guard legacy_addr_guard_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_prog32(cfg_prog32), .cfg_data32(cfg_data32),
  .req_valid(req_valid), .req_fetch(req_fetch), .mode_q(mode_q),
  .addr_exc(addr_exc), .vec_exc(vec_exc), .fetch_pc(fetch_pc)
);

// File: tb/legacy_addr_guard_tb.sv
`timescale 1ns/1ps
module legacy_addr_guard_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic cfg_prog32 = 0, cfg_data32 = 0, cfg_vec_rd_trap = 0;
  logic mode_wr_en = 0;
  logic [4:0] mode_wr_data = 0;
  logic req_valid = 0, req_write = 0, req_fetch = 0;
  logic [31:0] req_addr = 0;
  logic [4:0] mode_q;
  logic addr_exc, vec_exc;
  logic [31:0] fetch_pc;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  legacy_addr_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_prog32(cfg_prog32), .cfg_data32(cfg_data32),
    .cfg_vec_rd_trap(cfg_vec_rd_trap), .mode_wr_en(mode_wr_en),
    .mode_wr_data(mode_wr_data), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_fetch(req_fetch), .mode_q(mode_q),
    .addr_exc(addr_exc), .vec_exc(vec_exc), .fetch_pc(fetch_pc)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic do_reset(logic p32);
    @(negedge clk);
    rst_n = 0; cfg_prog32 = p32; req_valid = 0; mode_wr_en = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    chk("R1 reset mode", {27'd0, mode_q}, p32 ? 32'h13 : 32'h03);
  endtask

  task automatic write_mode(logic [4:0] v, logic [4:0] exp);
    @(negedge clk);
    mode_wr_en = 1; mode_wr_data = v;
    @(negedge clk);
    mode_wr_en = 0;
    chk(cfg_prog32 ? "R3 mode write" : "R2 mode lock", {27'd0, mode_q}, {27'd0, exp});
  endtask

  logic [31:0] addrs [9] = '{32'h0, 32'h4, 32'h1C, 32'h1F, 32'h20,
                             32'h03FF_FFFF, 32'h0400_0000, 32'h8000_0000, 32'hFFFF_FFFF};

  initial begin
    logic [4:0] m;
    logic ea, ev;
    logic [31:0] epc;
    do_reset(1'b0);
    write_mode(5'b10010, 5'b00010);
    write_mode(5'b11111, 5'b00011);
    do_reset(1'b1);
    write_mode(5'b00000, 5'b00000);
    write_mode(5'b10111, 5'b10111);

    for (int c = 0; c < 8; c++) begin
      for (int mi = 0; mi < 2; mi++) begin
        do_reset(c[0]);
        cfg_data32 = c[1]; cfg_vec_rd_trap = c[2];
        if (c[0]) begin
          write_mode(mi ? 5'b10011 : 5'b00011, mi ? 5'b10011 : 5'b00011);
          m = mi ? 5'b10011 : 5'b00011;
        end else m = 5'b00011;
        for (int a = 0; a < 9; a++)
          for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            req_addr = addrs[a]; req_valid = k[0]; req_write = k[1]; req_fetch = k[2];
            #1;
            ea = k[0] && !k[2] && !c[0] && !c[1] && (addrs[a] >= 32'h0400_0000);
            ev = k[0] && !k[2] && c[0] && !m[4] && (addrs[a] < 32'h20) && (k[1] || c[2]);
            epc = c[0] ? addrs[a] : (addrs[a] & 32'h03FF_FFFC);
            if (!k[0]) begin
              chk("R10 idle addr_exc", {31'd0, addr_exc}, 0);
              chk("R10 idle vec_exc", {31'd0, vec_exc}, 0);
            end else if (k[2]) begin
              chk("R5 fetch addr_exc", {31'd0, addr_exc}, 0);
              chk("R7 fetch vec_exc", {31'd0, vec_exc}, 0);
            end else begin
              chk(c[0] || c[1] ? "R5 addr_exc" : "R4 addr_exc", {31'd0, addr_exc}, {31'd0, ea});
              chk(!k[1] ? "R8 read vec_exc" : (m[4] || !c[0]) ? "R9 vec_exc" : "R6 vec_exc",
                  {31'd0, vec_exc}, {31'd0, ev});
            end
            chk("R11 fetch_pc", fetch_pc, epc);
          end
        req_valid = 0;
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule